// File: doc/BRIEF.md
# Cache Injection Snoop Controller

This block sits beside one core's private first-level data cache and watches a shared coherence bus. Besides ordinary reads, snoop invalidations and local miss fills, it understands one extra bus command: an external fill. That command carries a target core number, a line address and a whole line of data. It lets an I/O agent push arriving message data straight into the cache of the core that will consume it.

Each command is sampled in a single cycle. The target number is compared with this cache's own number, which comes in on a strap input. On a match, the line is written into a small direct-mapped tag/data store and marked Modified. On a mismatch, any copy this cache holds of the addressed line is dropped. Installing a line over a dirty line with a different tag first sends the old contents out on a writeback port. Every command gets a registered response one cycle after it is sampled. The response reports whether the line was present, the line's resulting state and data, and whether the command was an injection aimed at this core.

Top module: `inj_snoop_ctl`

## Requirements
- R1: After reset every line is Invalid, `rsp_valid` and `wb_valid` are low, and a read of any address misses.
- R2: A command sampled with `cmd_valid` high produces `rsp_valid` high in the next cycle. A cycle without a command produces `rsp_valid` low in the next cycle.
- R3: Command encoding on `cmd_op`: 0 is a local fill, 1 a read, 2 a snoop invalidate, 3 an external fill. States on `rsp_state` are I=0, S=1, E=2, M=3. The low log2(SETS) bits of `cmd_addr` select the set and the remaining bits form the tag. A local fill installs the line as E with `cmd_data`.
- R4: An external fill whose `cmd_core` equals `self_id` installs `cmd_data` under the command's tag. The response shows state M, `rsp_inject`=1 and the new data.
- R5: An external fill to this core for a line already present replaces its data, leaves it M, reports `rsp_hit`=1 and raises no writeback.
- R6: An external fill for another core invalidates a present copy of that line without a writeback, even when the copy is M. The response shows state I, `rsp_inject`=0 and data 0. A line with a different tag in the same set is left untouched.
- R7: A local fill or a matching external fill that lands on an M line with a different tag raises `wb_valid` in the response cycle. `wb_addr` carries the victim's address and `wb_data` its old data. No other fill raises `wb_valid`.
- R8: A read hit returns the stored state and data and leaves the line unchanged. A read miss returns `rsp_hit`=0, state I and data 0. Reads never raise `wb_valid`.
- R9: A snoop invalidate makes a present line I. If the line was M, it raises `wb_valid` with that line's address and data.
- R10: The core comparison uses all log2(N_CORES) bits of the core number, so numbers that differ only in the high bit or only in the low bit both count as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| self_id | input | ID_W | This cache's core number (strap) |
| cmd_valid | input | 1 | Bus command present this cycle |
| cmd_op | input | 2 | Command code |
| cmd_core | input | ID_W | Target core of an external fill |
| cmd_addr | input | ADDR_W | Line address |
| cmd_data | input | LINE_W | Line data for fills |
| rsp_valid | output | 1 | Response for the command of the previous cycle |
| rsp_hit | output | 1 | Addressed line was present before the command |
| rsp_inject | output | 1 | Command was an external fill aimed at this core |
| rsp_state | output | 2 | Line state after the command |
| rsp_data | output | LINE_W | Line data after the command, 0 when Invalid |
| wb_valid | output | 1 | Dirty line leaves the cache |
| wb_addr | output | ADDR_W | Address of the line written back |
| wb_data | output | LINE_W | Data of the line written back |

## Verification
The bench aims injections at lines that are absent, present clean, present dirty and aliased in the same set, alternating between matching and foreign core numbers. A controller that treated a foreign injection as a miss would leave a stale copy readable. One that wrote back a dirty copy it was told to drop would push superseded data to memory. One that skipped the victim writeback would silently lose a dirty line. A comparator that ignored a bit would accept another core's line as its own. Random command streams over a narrow address pool keep set conflicts frequent, and a bench model predicts every response and writeback.

// File: rtl/inj_pkg.sv
package inj_pkg;

  typedef enum logic [1:0] {
    OP_FILL  = 2'd0,
    OP_READ  = 2'd1,
    OP_INVAL = 2'd2,
    OP_XFILL = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;

  // State of the addressed line once the command has taken effect.
  function automatic mesi_e next_state(op_e op, logic hit, logic mine, mesi_e old);
    mesi_e r;
    unique case (op)
      OP_FILL:  r = ST_E;
      OP_READ:  r = hit ? old : ST_I;
      OP_INVAL: r = ST_I;
      default:  r = mine ? ST_M : ST_I;
    endcase
    return r;
  endfunction

  // Does the command push the stored line out to memory?
  function automatic logic needs_wb(op_e op, logic hit, logic mine, mesi_e stored);
    logic installs;
    installs = (op == OP_FILL) || mine;
    return (stored == ST_M) && ((installs && !hit) || (op == OP_INVAL && hit));
  endfunction

endpackage

// File: rtl/inj_id_cmp.sv
module inj_id_cmp #(
  parameter int ID_W = 2
) (
  input  logic [ID_W-1:0] a,
  input  logic [ID_W-1:0] b,
  output logic            eq
);
  logic [ID_W-1:0] diff;
  assign diff = a ^ b;
  assign eq   = (diff == '0);
endmodule

// File: rtl/inj_line_store.sv
module inj_line_store #(
  parameter int SETS   = 8,
  parameter int TAG_W  = 9,
  parameter int LINE_W = 64,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [1:0]        wr_state,
  input  logic [LINE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [1:0]        rd_state,
  output logic [LINE_W-1:0] rd_data
);
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [1:0]        st_q   [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic sel;
    assign sel = we && (wr_idx == IDX_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[s]  <= '0;
        st_q[s]   <= 2'd0;
        data_q[s] <= '0;
      end else if (sel) begin
        tag_q[s]  <= wr_tag;
        st_q[s]   <= wr_state;
        data_q[s] <= wr_data;
      end
    end
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_state = st_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/inj_snoop_ctl.sv
module inj_snoop_ctl
  import inj_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 12,
  parameter int SETS    = 8,
  parameter int LINE_W  = 64,
  parameter int ID_W    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   self_id,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ID_W-1:0]   cmd_core,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LINE_W-1:0] cmd_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_inject,
  output logic [1:0]        rsp_state,
  output logic [LINE_W-1:0] rsp_data,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  op_e               op;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [TAG_W-1:0]  st_tag;
  logic [1:0]        st_raw;
  mesi_e             st_old;
  logic [LINE_W-1:0] st_data;
  logic              id_eq;

  // Named events for the checks below.
  logic  line_hit, ev_inject, ev_kill, ev_evict, installs;
  mesi_e nxt;
  logic              we;
  logic [TAG_W-1:0]  wr_tag;
  logic [LINE_W-1:0] wr_data;

  assign op     = op_e'(cmd_op);
  assign idx    = cmd_addr[IDX_W-1:0];
  assign tag    = cmd_addr[ADDR_W-1:IDX_W];
  assign st_old = mesi_e'(st_raw);

  inj_id_cmp #(.ID_W(ID_W)) u_id_cmp (
    .a  (cmd_core),
    .b  (self_id),
    .eq (id_eq)
  );

  assign line_hit  = (st_old != ST_I) && (st_tag == tag);
  assign ev_inject = cmd_valid && (op == OP_XFILL) && id_eq;
  assign ev_kill   = cmd_valid && (op == OP_XFILL) && !id_eq && line_hit;
  assign installs  = cmd_valid && ((op == OP_FILL) || ev_inject);
  assign nxt       = next_state(op, line_hit, ev_inject, st_old);
  assign ev_evict  = cmd_valid && needs_wb(op, line_hit, ev_inject, st_old);

  assign we      = installs || ev_kill || (cmd_valid && op == OP_INVAL && line_hit);
  assign wr_tag  = installs ? tag : st_tag;
  assign wr_data = installs ? cmd_data : st_data;

  inj_line_store #(
    .SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W), .IDX_W(IDX_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (we),
    .wr_idx   (idx),
    .wr_tag   (wr_tag),
    .wr_state (nxt),
    .wr_data  (wr_data),
    .rd_idx   (idx),
    .rd_tag   (st_tag),
    .rd_state (st_raw),
    .rd_data  (st_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_inject <= 1'b0;
      rsp_state  <= ST_I;
      rsp_data   <= '0;
      wb_valid   <= 1'b0;
      wb_addr    <= '0;
      wb_data    <= '0;
    end else begin
      rsp_valid  <= cmd_valid;
      rsp_hit    <= cmd_valid && line_hit;
      rsp_inject <= ev_inject;
      rsp_state  <= cmd_valid ? nxt : ST_I;
      rsp_data   <= (cmd_valid && nxt != ST_I) ? wr_data : '0;
      wb_valid   <= ev_evict;
      wb_addr    <= ev_evict ? {st_tag, idx} : '0;
      wb_data    <= ev_evict ? st_data : '0;
    end
  end

  // R2: fixed one-cycle response latency
  a_r2_rsp_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);
  // R4: an injection aimed here always ends Modified
  a_r4_inject_modified: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_inject |-> (rsp_valid && rsp_state == ST_M));
  // R6: a foreign injection leaves the line Invalid and writes nothing back
  a_r6_foreign_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3 && cmd_core != self_id) |=> (rsp_state == ST_I && !wb_valid));
  // R7: a writeback is always part of a response
  a_r7_wb_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> rsp_valid);
  // R8: reads never evict
  a_r8_read_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1) |=> !wb_valid);
endmodule

// File: tb/test_inj_snoop_ctl.sv
module test_inj_snoop_ctl;
  localparam int N_CORES = 4;
  localparam int ADDR_W  = 12;
  localparam int SETS    = 8;
  localparam int LINE_W  = 64;
  localparam int ID_W    = 2;
  localparam int IDX_W   = 3;
  localparam int TAG_W   = ADDR_W - IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ID_W-1:0]   self_id = 2'd2;
  logic              cmd_valid = 1'b0;
  logic [1:0]        cmd_op = 2'd0;
  logic [ID_W-1:0]   cmd_core = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [LINE_W-1:0] cmd_data = '0;
  logic              rsp_valid, rsp_hit, rsp_inject, wb_valid;
  logic [1:0]        rsp_state;
  logic [LINE_W-1:0] rsp_data, wb_data;
  logic [ADDR_W-1:0] wb_addr;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  inj_snoop_ctl #(.N_CORES(N_CORES), .ADDR_W(ADDR_W), .SETS(SETS), .LINE_W(LINE_W)) i_inj_snoop_ctl (
    .clk(clk), .rst_n(rst_n), .self_id(self_id),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_core(cmd_core),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_inject(rsp_inject),
    .rsp_state(rsp_state), .rsp_data(rsp_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  // Bench model of the cache contents.
  logic [TAG_W-1:0]  m_tag  [SETS];
  logic [1:0]        m_st   [SETS];
  logic [LINE_W-1:0] m_data [SETS];

  task automatic chk(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Expected state of the addressed line after a command.
  function automatic logic [1:0] exp_state(logic [1:0] op, logic present, logic own, logic [1:0] held);
    if (op == 2'd0) return 2'd2;
    if (op == 2'd3 && own) return 2'd3;
    if (op == 2'd1 && present) return held;
    return 2'd0;
  endfunction

  task automatic run_cmd(input logic [1:0] op, input logic [ID_W-1:0] core,
                         input logic [ADDR_W-1:0] addr, input logic [LINE_W-1:0] data,
                         input string req);
    logic [IDX_W-1:0] ix;
    logic [TAG_W-1:0] tg;
    logic present, own, e_wb, puts;
    logic [1:0] e_st;
    logic [LINE_W-1:0] e_data;
    logic [ADDR_W-1:0] e_wba;
    logic [LINE_W-1:0] e_wbd;
    ix = addr[IDX_W-1:0];
    tg = addr[ADDR_W-1:IDX_W];
    present = (m_st[ix] != 2'd0) && (m_tag[ix] == tg);
    own  = (op == 2'd3) && (core == self_id);
    puts = (op == 2'd0) || own;
    e_st = exp_state(op, present, own, m_st[ix]);
    e_data = (e_st == 2'd0) ? '0 : (puts ? data : m_data[ix]);
    e_wb = (m_st[ix] == 2'd3) && ((puts && !present) || (op == 2'd2 && present));
    e_wba = e_wb ? {m_tag[ix], ix} : '0;
    e_wbd = e_wb ? m_data[ix] : '0;
    if (puts) begin
      m_tag[ix] = tg; m_st[ix] = e_st; m_data[ix] = data;
    end else if ((op == 2'd2 || op == 2'd3) && present) begin
      m_st[ix] = 2'd0;
    end
    cmd_valid = 1'b1; cmd_op = op; cmd_core = core; cmd_addr = addr; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(rsp_valid && rsp_hit == present && rsp_inject == own && rsp_state == e_st,
        {req, " response flags"}, {rsp_valid, rsp_hit, rsp_inject, rsp_state},
        {1'b1, present, own, e_st});
    chk(rsp_data == e_data, {req, " response data"}, rsp_data, e_data);
    chk(wb_valid == e_wb && wb_addr == e_wba && wb_data == e_wbd, {req, " writeback"},
        {wb_valid, wb_addr, wb_data}, {e_wb, e_wba, e_wbd});
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < SETS; s++) begin
      m_tag[s] = '0; m_st[s] = 2'd0; m_data[s] = '0;
    end
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !wb_valid, "R1 outputs idle in reset", {rsp_valid, wb_valid}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmd(2'd1, 2'd0, 12'h005, '0, "R1 read after reset misses");
    // R2: idle cycle gives no response
    @(negedge clk);
    chk(!rsp_valid, "R2 no response without command", rsp_valid, 1'b0);
    // R4 / R8: inject then read
    run_cmd(2'd3, 2'd2, 12'h013, 64'hA0A0_0000_1111_2222, "R4 inject absent line");
    run_cmd(2'd1, 2'd1, 12'h013, '0, "R8 read injected line");
    // R5: re-inject present line
    run_cmd(2'd3, 2'd2, 12'h013, 64'hB0B0_3333_4444_5555, "R5 inject present line");
    run_cmd(2'd1, 2'd0, 12'h013, '0, "R5 read replaced data");
    // R6 / R10: foreign injection, differs in high bit of core number
    run_cmd(2'd3, 2'd0, 12'h013, 64'hDEAD_BEEF_0000_0001, "R6 R10 foreign drops dirty copy");
    run_cmd(2'd1, 2'd2, 12'h013, '0, "R6 read after drop misses");
    // R3: local fill gives E; foreign inject of aliasing tag leaves it alone
    run_cmd(2'd0, 2'd0, 12'h024, 64'hC0C0_6666_7777_8888, "R3 local fill exclusive");
    run_cmd(2'd3, 2'd3, 12'h014, 64'h1234_5678_9ABC_DEF0, "R10 foreign low bit, R6 absent line");
    run_cmd(2'd1, 2'd0, 12'h024, '0, "R6 other tag untouched");
    // R7: dirty victim on fill and on injection
    run_cmd(2'd3, 2'd2, 12'h00D, 64'h0D0D_0D0D_0D0D_0D0D, "R4 inject set5");
    run_cmd(2'd0, 2'd0, 12'h015, 64'h1515_1515_1515_1515, "R7 fill evicts dirty");
    run_cmd(2'd3, 2'd2, 12'h025, 64'h2525_2525_2525_2525, "R7 inject over clean no wb");
    run_cmd(2'd3, 2'd2, 12'h035, 64'h3535_3535_3535_3535, "R7 inject evicts dirty");
    // R9: invalidate dirty and clean lines
    run_cmd(2'd2, 2'd0, 12'h035, '0, "R9 invalidate dirty writes back");
    run_cmd(2'd2, 2'd0, 12'h024, '0, "R9 invalidate clean");
    run_cmd(2'd2, 2'd0, 12'h024, '0, "R9 invalidate absent");
    // Random mix over a narrow address pool.
    for (int n = 0; n < 600; n++) begin
      logic [1:0] rop;
      logic [ID_W-1:0] rcore;
      logic [ADDR_W-1:0] raddr;
      logic [LINE_W-1:0] rdata;
      rop   = 2'($urandom_range(0, 3));
      rcore = ID_W'($urandom_range(0, N_CORES - 1));
      raddr = {TAG_W'($urandom_range(0, 3)), IDX_W'($urandom_range(0, SETS - 1))};
      rdata = {$urandom, $urandom};
      case (rop)
        2'd0: run_cmd(rop, rcore, raddr, rdata, "R3 R7 random fill");
        2'd1: run_cmd(rop, rcore, raddr, rdata, "R8 random read");
        2'd2: run_cmd(rop, rcore, raddr, rdata, "R9 random invalidate");
        default: run_cmd(rop, rcore, raddr, rdata, "R4 R6 random inject");
      endcase
      if (n % 50 == 0) begin
        @(negedge clk);
        chk(!rsp_valid, "R2 random idle", rsp_valid, 1'b0);
      end
    end
    summary();
  end
endmodule